// File: doc/BRIEF.md
# Single-Slope Conversion Sequencer

This block is the digital side of a capacitor-discharge converter. While idle and during a sampling window, it keeps the discharge control low, so the storage capacitor follows the selected analog input. When a conversion is requested, it lets the capacitor track for a fixed number of clocks. It then raises the discharge control, which isolates the capacitor and starts a constant-current ramp down. At the same moment it starts an up-counter from zero.

A comparator reports whether the capacitor is still above the reference. When that report goes low, the counter value becomes the result. That value is proportional to the ramp time multiplied by the clock rate. A ramp that runs past the counter's full scale gives a saturated result with an overflow flag.

Each finished conversion produces a one-cycle valid pulse. The pulse carries the result and the index of the channel that was converted, and the channel select then moves on to the next input, wrapping after the last one. The capacitor, the current source and the comparator sit outside the block.

Top module: `ss_adc_seq`

## Requirements
- R1: While reset is asserted, and on leaving it, discharge, busy and res_valid are 0, chan_sel is 0 and res_data is 0.
- R2: A conv_req seen while idle starts a sampling window. During the window busy is 1 and discharge stays 0 for exactly SAMPLE_CYC clocks (16 by default), after which discharge goes to 1.
- R3: The counter starts at 0 in the first discharge clock and adds one per clock. Discharge stays 1 without a gap for res_data+1 clocks.
- R4: cmp_above (1 = capacitor above reference) passes through two flip-flops. If it falls T full clocks after discharge rises and stays low, the result is T+2.
- R5: If the count reaches 255 (all ones) while the synchronized comparator is still 1, the result is 255 and res_ovf is 1. Otherwise res_ovf is 0, including a result of exactly 255 reached by the comparator.
- R6: res_valid is a one-clock pulse. It rises on the same edge at which discharge falls and busy returns to 0.
- R7: res_chan reports the channel that was converted. chan_sel holds still during a conversion and advances by one modulo NUM_CH (default 4) at each result.
- R8: conv_req while busy is ignored. It produces no extra result and no extra channel step, and the block is idle after the conversion in progress ends.
- R9: res_data, res_chan and res_ovf hold their values until the next res_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_req | input | 1 | Request one conversion of the current channel |
| cmp_above | input | 1 | Asynchronous comparator output, 1 while capacitor is above reference |
| discharge | output | 1 | 0 = capacitor tracks input, 1 = isolated and ramping down |
| chan_sel | output | CH_W (2) | Analog channel being sampled |
| busy | output | 1 | Conversion in progress |
| res_valid | output | 1 | One-clock result strobe |
| res_data | output | CNT_W (8) | Latched count |
| res_chan | output | CH_W (2) | Channel the result belongs to |
| res_ovf | output | 1 | Count saturated without a comparator stop |

## Verification
The bench targets the edges of the count range. It uses a comparator fall at the very first discharge clock, which must give 2. It uses a fall timed so the count lands exactly on 255 without overflow, which catches a design that flags overflow on the value and not on the missing stop. It also uses falls one clock later and not at all, which must saturate with the flag set. A design that is off by one in the synchronizer depth or in the counter start shows up as a shifted result in every random trial. So does one that stretches or shortens the sampling window, because the bench counts the low-discharge clocks directly. Requests held high through a whole conversion would, in a design that honours them, show up as a second strobe, a skipped channel or a busy flag left standing.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_DISCH  = 2'd2
  } seq_state_e;

  // bits needed to index n items (at least one)
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ssadc_sync.sv
module ssadc_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= RST_VAL;
      sync_out <= RST_VAL;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end

  // a falling synchronized level must come from the input two edges back
  assert_sync_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_out) |-> !$past(async_in, 2));

endmodule

// File: rtl/ssadc_sample_timer.sv
module ssadc_sample_timer #(
  parameter int SAMPLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);

  localparam int TW = ssadc_pkg::idx_bits(SAMPLE_CYC);
  localparam logic [TW-1:0] LAST = TW'(SAMPLE_CYC - 1);

  logic [TW-1:0] tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tick_q <= '0;
    else if (!active)     tick_q <= '0;
    else if (tick_q != LAST) tick_q <= tick_q + 1'b1;
  end

  assign done = active && (tick_q == LAST);

  // the controller must leave the sampling window once the timer expires
  assert_window_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active);

endmodule

// File: rtl/ssadc_slope_counter.sv
module ssadc_slope_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] count,
  output logic             at_max
);

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (!run)    count <= '0;
    else if (!at_max) count <= count + 1'b1;
  end

  assign at_max = (count == FULL);

  assert_start_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (count == '0));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(at_max)) |-> (count == $past(count) + 1'b1));

endmodule

// File: rtl/ssadc_chan_step.sv
module ssadc_chan_step #(
  parameter int NUM_CH = 4,
  localparam int CH_W = ssadc_pkg::idx_bits(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  output logic [CH_W-1:0] chan
);

  logic [CH_W-1:0] chan_nx;

  generate
    if ((1 << CH_W) == NUM_CH) begin : g_pow2
      // natural rollover of the register gives the wrap
      assign chan_nx = chan + 1'b1;
    end else begin : g_wrap
      assign chan_nx = (chan == CH_W'(NUM_CH - 1)) ? '0 : chan + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chan <= '0;
    else if (advance) chan <= chan_nx;
  end

  assert_chan_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(chan) < NUM_CH);

  assert_chan_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(chan));

endmodule

// File: rtl/ss_adc_seq.sv
module ss_adc_seq #(
  parameter int CNT_W      = 8,
  parameter int NUM_CH     = 4,
  parameter int SAMPLE_CYC = 16,
  localparam int CH_W = ssadc_pkg::idx_bits(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_req,
  input  logic             cmp_above,
  output logic             discharge,
  output logic [CH_W-1:0]  chan_sel,
  output logic             busy,
  output logic             res_valid,
  output logic [CNT_W-1:0] res_data,
  output logic [CH_W-1:0]  res_chan,
  output logic             res_ovf
);

  import ssadc_pkg::*;

  // result chosen from the running count or clamped to full scale
  function automatic logic [CNT_W-1:0] pick_result(input logic [CNT_W-1:0] cnt,
                                                   input logic clamp);
    return clamp ? {CNT_W{1'b1}} : cnt;
  endfunction

  seq_state_e       state_q, state_d;
  logic             cmp_sync;
  logic             samp_done;
  logic [CNT_W-1:0] ramp_cnt;
  logic             ramp_full;

  // named internal events
  logic start_evt, hit_ref, sat_evt, finish;

  assign start_evt = (state_q == ST_IDLE)  && conv_req;
  assign hit_ref   = (state_q == ST_DISCH) && !cmp_sync;
  assign sat_evt   = (state_q == ST_DISCH) && cmp_sync && ramp_full;
  assign finish    = hit_ref || sat_evt;

  ssadc_sync #(.RST_VAL(1'b1)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (cmp_above),
    .sync_out (cmp_sync)
  );

  ssadc_sample_timer #(.SAMPLE_CYC(SAMPLE_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (state_q == ST_SAMPLE),
    .done   (samp_done)
  );

  ssadc_slope_counter #(.CNT_W(CNT_W)) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state_q == ST_DISCH),
    .count  (ramp_cnt),
    .at_max (ramp_full)
  );

  ssadc_chan_step #(.NUM_CH(NUM_CH)) u_chan (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (finish),
    .chan    (chan_sel)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start_evt) state_d = ST_SAMPLE;
      ST_SAMPLE: if (samp_done) state_d = ST_DISCH;
      ST_DISCH:  if (finish)    state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
      res_ovf   <= 1'b0;
    end else begin
      res_valid <= finish;
      if (finish) begin
        res_data <= pick_result(ramp_cnt, sat_evt);
        res_chan <= chan_sel;
        res_ovf  <= sat_evt;
      end
    end
  end

  assign discharge = (state_q == ST_DISCH);
  assign busy      = (state_q != ST_IDLE);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_release_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(discharge) |-> (res_valid && !busy));

  assert_sat_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ovf) |-> (res_data == {CNT_W{1'b1}}));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_data) && $stable(res_chan) && $stable(res_ovf)));

  assert_chan_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(chan_sel));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (discharge && conv_req) |=> (!busy || discharge));

endmodule

// File: tb/ss_adc_seq_test.sv
module ss_adc_seq_test;

  localparam int CNT_W  = 8;
  localparam int NUM_CH = 4;
  localparam int SCYC   = 16;
  localparam int FULL   = 255;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_req = 1'b0;
  logic       cmp_above = 1'b1;
  logic       discharge, busy, res_valid, res_ovf;
  logic [1:0] chan_sel, res_chan;
  logic [7:0] res_data;

  int total = 0;
  int bad = 0;
  int model_ch = 0;

  always #5 clk = ~clk;

  ss_adc_seq #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .SAMPLE_CYC(SCYC)) uut (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .cmp_above(cmp_above),
    .discharge(discharge), .chan_sel(chan_sel), .busy(busy),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
    .res_ovf(res_ovf)
  );

  function automatic int exp_res(input int t);
    return (t + 2 > FULL) ? FULL : t + 2;
  endfunction

  function automatic int exp_ovf(input int t);
    return (t + 2 > FULL) ? 1 : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one conversion; comparator falls t clocks after discharge rises
  task automatic do_conv(input int t, input bit hold_req);
    int n;
    int j;
    int gaps;
    int exp_ch;
    exp_ch = model_ch;
    @(negedge clk) conv_req = 1'b1;
    @(negedge clk) if (!hold_req) conv_req = 1'b0;
    check("R2 busy in window", int'(busy), 1);
    n = 0;
    while (!discharge && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check("R2 sample length", n, SCYC);
    check("R7 chan during conv", int'(chan_sel), exp_ch);
    j = 0;
    gaps = 0;
    if (t == 0) cmp_above = 1'b0;
    while (!res_valid && j < 1000) begin
      if (!discharge) gaps++;
      @(negedge clk);
      j++;
      if (j == t) cmp_above = 1'b0;
    end
    conv_req  = 1'b0;
    cmp_above = 1'b1;
    check("R4 result", int'(res_data), exp_res(t));
    check("R5 overflow", int'(res_ovf), exp_ovf(t));
    check("R7 result channel", int'(res_chan), exp_ch);
    check("R6 discharge low with strobe", int'(discharge), 0);
    check("R3 discharge length", j, exp_res(t) + 1);
    check("R3 no discharge gap", gaps, 0);
    model_ch = (model_ch + 1) % NUM_CH;
    @(negedge clk);
    check("R6 strobe one clock", int'(res_valid), 0);
    check("R9 data held", int'(res_data), exp_res(t));
    check("R7 chan advanced", int'(chan_sel), model_ch);
    if (hold_req) begin
      repeat (3) @(negedge clk);
      check("R8 idle after held request", int'(busy), 0);
      check("R8 no second strobe", int'(res_valid), 0);
      check("R8 no extra step", int'(chan_sel), model_ch);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 values while in reset
    check("R1 discharge", int'(discharge), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 valid", int'(res_valid), 0);
    check("R1 chan", int'(chan_sel), 0);
    check("R1 data", int'(res_data), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after release", int'(busy), 0);

    do_conv(0, 1'b0);     // earliest stop
    do_conv(253, 1'b0);   // exactly full scale, no overflow
    do_conv(254, 1'b0);   // one clock late: saturate
    do_conv(400, 1'b0);   // comparator never flips in time
    do_conv(17, 1'b1);    // request held through conversion
    for (int k = 0; k < 14; k++) begin
      do_conv(int'($urandom_range(260, 0)), ($urandom_range(3, 0) == 0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule